// File: doc/BRIEF.md
# Fully Associative Write-Back Byte Cache

This block is a small data cache between a processor port and a backing memory. The processor port is byte-addressed with a 32-bit address. The memory port moves one 32-bit word at a time. The cache has 64 lines, and each line holds a single 32-bit word. Every line records its word address as a 30-bit tag, together with a valid flag and a dirty flag. A lookup compares the request tag against every line in the same cycle, so any word may sit in any line.

Reads and writes are one byte wide. A miss on either kind of access fetches the whole word from memory before the line is installed, and a write miss merges its byte into the fetched word. When the cache is full, a tree pseudo-LRU picks the victim. A dirty victim is written back to memory before the fill is requested. The processor side takes one request at a time through a valid/ready pair and returns a one-cycle done pulse with a byte. The memory side issues one transaction at a time and holds it until the memory acknowledges it after any latency.

Top module: `fa_wb_cache`

## Requirements
- R1: During reset and after it, every line is invalid and clean, and the pseudo-LRU state is all zero. In the cycle after reset, `req_ready` is 1, `rsp_done` is 0 and `mem_req` is 0, so the first access to any word is a miss.
- R2: Address bits 1:0 select a byte, and in that byte lane `rsp_rbyte` = word[8*off+7 : 8*off]. Address bits 31:2 form the tag. A read that matches a valid line is a hit. At most one line ever matches. A hit raises `rsp_done` with the byte in the cycle after the accepting edge, and it starts no memory transaction.
- R3: A read miss issues `mem_req` with `mem_we`=0 and `mem_addr` equal to the request tag. It installs the returned word as a valid, clean line and returns the requested byte. `rsp_done` rises in the cycle after the edge at which `mem_ack` is sampled for that fill.
- R4: A write hit changes only the addressed byte of the matching line and marks the line dirty. `rsp_done` follows in the next cycle, with `rsp_rbyte` equal to the written byte.
- R5: A write miss fetches the word first and merges the written byte into its lane. It installs the result as a valid, dirty line and answers with the written byte. The other three bytes keep their memory values.
- R6: A miss uses the lowest-indexed invalid line when any line is invalid. Only when every line is valid is the pseudo-LRU victim replaced.
- R7: The pseudo-LRU state is a binary tree of 63 node bits. Node 1 is the root, and node n has children 2n and 2n+1; leaf 64+i is line i. The victim is found by starting at the root and stepping to child 2n+bit[n] six times. Every read hit, write hit and fill of line i sets each node on the path of line i to point away from it: the bit becomes 0 when the path goes right and 1 when it goes left.
- R8: When the victim is dirty, a write with `mem_we`=1 is issued first, carrying the victim's tag as `mem_addr` and its word as `mem_wdata`. The fill read is issued only after that write is acknowledged. A clean victim causes no memory write.
- R9: At most one memory transaction is in flight. While `mem_req` is 1 and `mem_ack` has not been sampled, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R10: `req_ready` falls in the cycle after a miss is accepted and stays 0 until the cycle in which that miss's `rsp_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 32 | Byte address |
| req_wbyte | input | 8 | Byte to write |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rbyte | output | 8 | Read byte, or the written byte for writes |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | 30 | Word address of the memory transaction |
| mem_wdata | output | 32 | Word being written back |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Fill word, valid with mem_ack |

## Verification
A hit is due exactly one cycle after its accepting edge. A miss is due one cycle after the edge that samples the acknowledge of its fill, and before that fill come zero or one write-backs, each with a latency of zero to three cycles. The bench drives its inputs just after the rising edge and samples on the falling edge. It checks a hit's done pulse and the fall of ready after a miss at the first falling edge after acceptance. The responses themselves are matched in order from a scoreboard queue at whatever cycle they arrive. The memory model compares each transaction, in order, against a queue of expected write-backs and fills from a reference model of the lines and the tree state. At the end of the run, the memory contents are compared with the expected contents.

// File: rtl/fac_pkg.sv
package fac_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int OFF_W  = $clog2(WORD_W / BYTE_W);

  typedef enum logic [1:0] {
    S_IDLE,
    S_WBACK,
    S_FILL
  } state_t;

  function automatic logic [BYTE_W-1:0] get_byte(input logic [WORD_W-1:0] w,
                                                 input logic [OFF_W-1:0]  o);
    return w[BYTE_W*o +: BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic [OFF_W-1:0]  o,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[BYTE_W*o +: BYTE_W] = b;
    return r;
  endfunction

endpackage

// File: rtl/fac_line_store.sv
module fac_line_store import fac_pkg::*; #(
  parameter int LINES = 64,
  parameter int TAG_W = 30,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_dirty,
  output logic [TAG_W-1:0]  tag_o  [LINES],
  output logic [WORD_W-1:0] word_o [LINES],
  output logic [LINES-1:0]  valid_o,
  output logic [LINES-1:0]  dirty_o
);

  // flags need a reset; tag and data storage carry none
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= '0;
      dirty_o <= '0;
    end else if (wr_en) begin
      valid_o[wr_idx] <= 1'b1;
      dirty_o[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_o[wr_idx]  <= wr_tag;
      word_o[wr_idx] <= wr_word;
    end
  end

endmodule

// File: rtl/fac_tag_match.sv
module fac_tag_match #(
  parameter int LINES = 64,
  parameter int TAG_W = 30,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] tag_i [LINES],
  input  logic [LINES-1:0] valid_i,
  output logic [LINES-1:0] hit_vec,
  output logic             hit_any,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tag_i[g] == req_tag);
  end

  assign hit_any  = |hit_vec;
  assign free_any = ~&valid_i;

  // scan from the top so the lowest index wins
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/fac_plru.sv
module fac_plru #(
  parameter int LINES = 64,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  // node n has children 2n and 2n+1; bit 0 points the walk left
  logic [LINES-1:1] node_q;

  always_comb begin
    int unsigned n;
    n = 1;
    for (int l = 0; l < IDX_W; l++) begin
      n = 2 * n + (node_q[n] ? 1 : 0);
    end
    victim_idx = IDX_W'(n - LINES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      node_q <= '0;
    end else if (touch_en) begin
      for (int l = 0; l < IDX_W; l++) begin
        node_q[(LINES + int'(touch_idx)) >> (IDX_W - l)] <= ~touch_idx[IDX_W-1-l];
      end
    end
  end

endmodule

// File: rtl/fa_wb_cache.sv
module fa_wb_cache import fac_pkg::*; #(
  parameter int LINES  = 64,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [BYTE_W-1:0]       req_wbyte,
  output logic                    req_ready,
  output logic                    rsp_done,
  output logic [BYTE_W-1:0]       rsp_rbyte,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [WORD_W-1:0]       mem_rdata
);

  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(LINES);

  state_t             st_q;
  logic               r_we;
  logic [TAG_W-1:0]   r_tag;
  logic [OFF_W-1:0]   r_off;
  logic [BYTE_W-1:0]  r_byte;
  logic [IDX_W-1:0]   r_slot;

  logic [TAG_W-1:0]   tag_a [LINES];
  logic [WORD_W-1:0]  dat_a [LINES];
  logic [LINES-1:0]   val_v, dty_v;

  logic [LINES-1:0]   hit_vec;
  logic               hit_any, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx, vic_idx, alloc_idx;

  logic [TAG_W-1:0]   req_tag;
  logic [OFF_W-1:0]   req_off;
  logic               accept;

  logic               wr_en, wr_dirty, tch_en;
  logic [IDX_W-1:0]   wr_idx, tch_idx;
  logic [TAG_W-1:0]   wr_tag;
  logic [WORD_W-1:0]  wr_word, hit_word, fill_word;

  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign req_off   = req_addr[OFF_W-1:0];
  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign alloc_idx = free_any ? free_idx : vic_idx;
  assign hit_word  = dat_a[hit_idx];
  assign fill_word = r_we ? put_byte(mem_rdata, r_off, r_byte) : mem_rdata;

  fac_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_word  (wr_word),
    .wr_dirty (wr_dirty),
    .tag_o    (tag_a),
    .word_o   (dat_a),
    .valid_o  (val_v),
    .dirty_o  (dty_v)
  );

  fac_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .req_tag  (req_tag),
    .tag_i    (tag_a),
    .valid_i  (val_v),
    .hit_vec  (hit_vec),
    .hit_any  (hit_any),
    .hit_idx  (hit_idx),
    .free_any (free_any),
    .free_idx (free_idx)
  );

  fac_plru #(.LINES(LINES)) u_plru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (tch_en),
    .touch_idx  (tch_idx),
    .victim_idx (vic_idx)
  );

  // single line write port: byte update on a write hit, install on fill
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = hit_idx;
    wr_tag   = req_tag;
    wr_word  = put_byte(hit_word, req_off, req_wbyte);
    wr_dirty = 1'b1;
    tch_en   = 1'b0;
    tch_idx  = hit_idx;
    if (accept && hit_any) begin
      tch_en = 1'b1;
      wr_en  = req_write;
    end else if (st_q == S_FILL && mem_ack) begin
      wr_en    = 1'b1;
      wr_idx   = r_slot;
      wr_tag   = r_tag;
      wr_word  = fill_word;
      wr_dirty = r_we;
      tch_en   = 1'b1;
      tch_idx  = r_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      rsp_done  <= 1'b0;
      rsp_rbyte <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      r_we      <= 1'b0;
      r_tag     <= '0;
      r_off     <= '0;
      r_byte    <= '0;
      r_slot    <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (accept && hit_any) begin
            rsp_done  <= 1'b1;
            rsp_rbyte <= req_write ? req_wbyte : get_byte(hit_word, req_off);
          end else if (accept) begin
            r_we    <= req_write;
            r_tag   <= req_tag;
            r_off   <= req_off;
            r_byte  <= req_wbyte;
            r_slot  <= alloc_idx;
            mem_req <= 1'b1;
            if (!free_any && dty_v[vic_idx]) begin
              st_q      <= S_WBACK;
              mem_we    <= 1'b1;
              mem_addr  <= tag_a[vic_idx];
              mem_wdata <= dat_a[vic_idx];
            end else begin
              st_q     <= S_FILL;
              mem_we   <= 1'b0;
              mem_addr <= req_tag;
            end
          end
        end
        S_WBACK: begin
          if (mem_ack) begin
            st_q     <= S_FILL;
            mem_we   <= 1'b0;
            mem_addr <= r_tag;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            st_q      <= S_IDLE;
            mem_req   <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_rbyte <= r_we ? r_byte : get_byte(mem_rdata, r_off);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fa_wb_cache_chk.sv
module fa_wb_cache_chk #(
  parameter int LINES  = 64,
  parameter int MADR_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [MADR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              hit_any,
  input logic [LINES-1:0]  hit_vec
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_done && !mem_req));

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R2
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit_any) |=> (rsp_done && req_ready));

  // R10
  miss_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !hit_any) |=> (!req_ready && !rsp_done));

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> (rsp_done && !mem_req));

  // R8
  wback_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we) |=> (mem_req && !mem_we));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

endmodule

bind fa_wb_cache fa_wb_cache_chk #(.LINES(LINES), .MADR_W(ADDR_W - 2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .hit_any   (hit_any),
  .hit_vec   (hit_vec)
);

// File: tb/sim_fa_wb_cache.sv
module sim_fa_wb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int LVL   = $clog2(LINES);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wbyte = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rbyte;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fa_wb_cache #(.LINES(LINES), .ADDR_W(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wbyte(req_wbyte), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rbyte(rsp_rbyte), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic void chk(input bit ok, input string rq,
                              input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endfunction

  // ---------------- reference model ----------------
  logic        rv [LINES];
  logic        rd [LINES];
  logic [29:0] rt [LINES];
  logic [31:0] rw [LINES];
  bit          pl [LINES];
  logic [31:0] ref_mem [logic [29:0]];
  logic [31:0] act_mem [logic [29:0]];

  typedef struct packed { logic we; logic [29:0] addr; logic [31:0] data; } mop_t;
  mop_t        exp_mem [$];
  logic [7:0]  exp_rsp [$];
  string       exp_tag [$];

  function automatic logic [31:0] seed_word(input logic [29:0] a);
    return ({a, 2'b01} * 32'h9E37_79B1) ^ 32'h5A17_C3E4;
  endfunction

  function automatic logic [31:0] rmem(input logic [29:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
  endfunction

  function automatic int pick_victim();
    int n = 1;
    for (int l = 0; l < LVL; l++) n = 2 * n + (pl[n] ? 1 : 0);
    return n - LINES;
  endfunction

  function automatic void touch(input int i);
    for (int l = 0; l < LVL; l++)
      pl[(LINES + i) >> (LVL - l)] = (((i >> (LVL - 1 - l)) & 1) == 0);
  endfunction

  // ---------------- driver ----------------
  task automatic issue(input bit we, input logic [31:0] addr, input logic [7:0] b);
    logic [29:0] t;
    logic [1:0]  off;
    logic [31:0] w;
    logic [7:0]  e;
    string       rq;
    int          h, s;
    t   = addr[31:2];
    off = addr[1:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    h = -1;
    for (int i = 0; i < LINES; i++) if (rv[i] && rt[i] == t) h = i;
    if (h >= 0) begin
      if (we) begin
        rw[h][8*off +: 8] = b; rd[h] = 1'b1; e = b; rq = "R4 write hit";
      end else begin
        e = rw[h][8*off +: 8]; rq = "R2 read hit";
      end
      touch(h);
    end else begin
      s = -1;
      for (int i = LINES - 1; i >= 0; i--) if (!rv[i]) s = i;
      if (s < 0) begin
        s = pick_victim();
        if (rd[s]) begin
          exp_mem.push_back({1'b1, rt[s], rw[s]});
          ref_mem[rt[s]] = rw[s];
        end
      end
      exp_mem.push_back({1'b0, t, 32'h0});
      w = rmem(t);
      if (we) w[8*off +: 8] = b;
      rv[s] = 1'b1; rd[s] = we; rt[s] = t; rw[s] = w;
      touch(s);
      e  = we ? b : w[8*off +: 8];
      rq = we ? "R5 write miss" : "R3 read miss";
    end
    exp_rsp.push_back(e);
    exp_tag.push_back(rq);
    req_valid = 1'b1; req_write = we; req_addr = addr; req_wbyte = b;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    if (h >= 0)
      chk(rsp_done && req_ready && !mem_req, "R2 hit done one cycle later, no memory traffic",
          {rsp_done, req_ready, mem_req}, 3'b110);
    else
      chk(!req_ready && !rsp_done && mem_req, "R10 miss holds ready low",
          {rsp_done, req_ready, mem_req}, 3'b001);
  endtask

  // ---------------- response monitor (scoreboard) ----------------
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (exp_rsp.size() == 0) begin
        chk(1'b0, "R2 unexpected done pulse", 1, 0);
      end else begin
        logic [7:0] e;
        string rq;
        e  = exp_rsp.pop_front();
        rq = exp_tag.pop_front();
        chk(rsp_rbyte == e, rq, rsp_rbyte, e);
      end
    end
  end

  // ---------------- memory model ----------------
  bit          m_busy = 1'b0;
  int          m_cnt = 0;
  mop_t        m_op;

  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      m_busy  = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else begin
      if (!m_busy && mem_req) begin
        m_op = {mem_we, mem_addr, mem_wdata};
        if (exp_mem.size() == 0) begin
          chk(1'b0, "R9 unexpected memory transaction", {mem_we, mem_addr}, 0);
        end else begin
          mop_t x;
          x = exp_mem.pop_front();
          if (x.we)
            chk(m_op == x, "R6 R7 R8 write-back victim and order", m_op, x);
          else
            chk({m_op.we, m_op.addr} == {x.we, x.addr}, "R3 R5 fill address",
                {m_op.we, m_op.addr}, {x.we, x.addr});
        end
        if (mem_we) act_mem[mem_addr] = mem_wdata;
        m_cnt  = int'(mem_addr[1:0] ^ mem_addr[3:2]);
        m_busy = 1'b1;
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          chk(mem_req && {mem_we, mem_addr, mem_wdata} == m_op, "R9 request held until ack",
              {mem_we, mem_addr}, {m_op.we, m_op.addr});
          mem_rdata = act_mem.exists(m_op.addr) ? act_mem[m_op.addr] : seed_word(m_op.addr);
          mem_ack   = 1'b1;
          m_busy    = 1'b0;
        end else begin
          m_cnt--;
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  logic [31:0] lf = 32'h1ACE_B00C;

  initial begin
    for (int i = 0; i < LINES; i++) begin
      rv[i] = 1'b0; rd[i] = 1'b0; rt[i] = '0; rw[i] = '0; pl[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_done && !mem_req, "R1 reset state",
        {req_ready, rsp_done, mem_req}, 3'b100);

    // R1 R3 first read misses, then R2 hits on all four lanes
    issue(1'b0, 32'h0000_1000, 8'h00);
    for (int k = 0; k < 4; k++) issue(1'b0, 32'h0000_1000 + k, 8'h00);
    // R4 write hit, neighbours untouched
    issue(1'b1, 32'h0000_1001, 8'hC7);
    for (int k = 0; k < 4; k++) issue(1'b0, 32'h0000_1000 + k, 8'h00);
    // R5 write miss merges into fetched word
    issue(1'b1, 32'h0000_2002, 8'h3E);
    for (int k = 0; k < 4; k++) issue(1'b0, 32'h0000_2000 + k, 8'h00);
    // R6 fill the remaining lines: invalid lines taken, no write-back expected
    for (int i = 0; i < LINES - 2; i++)
      issue(i % 3 == 0, 32'h0001_0000 + 32'(i * 4) + 32'(i % 4), 8'(i + 8'h40));
    // R7 shape the tree with hits
    issue(1'b0, 32'h0000_1003, 8'h00);
    issue(1'b1, 32'h0001_0014, 8'h99);
    issue(1'b0, 32'h0001_0044, 8'h00);
    // R8 evictions, dirty and clean victims
    for (int i = 0; i < 12; i++)
      issue(i % 2 == 1, 32'h0002_0000 + 32'(i * 4), 8'(8'hA0 + i));
    // mixed traffic over a pool larger than the cache
    for (int i = 0; i < 500; i++) begin
      logic [31:0] a;
      lf = lf * 32'd1664525 + 32'd1013904223;
      a  = 32'h0001_0000 + ((lf[23:16] % 32'd96) << 2) + 32'(lf[5:4]);
      issue(lf[9:8] == 2'b00 || lf[9:8] == 2'b01 && lf[12], a, lf[31:24]);
    end
    repeat (20) @(negedge clk);
    chk(exp_rsp.size() == 0, "R3 all responses delivered", exp_rsp.size(), 0);
    chk(exp_mem.size() == 0, "R8 all memory transactions seen", exp_mem.size(), 0);
    foreach (ref_mem[k])
      chk(act_mem.exists(k) && act_mem[k] == ref_mem[k], "R8 written-back memory contents",
          act_mem.exists(k) ? act_mem[k] : 32'hX, ref_mem[k]);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule